// File: doc/BRIEF.md
# Aliased Control and Status Register Bank

This block is the register front end of a multi-channel accelerator. A simple 32-bit bus with one address and a write strobe reaches a global control word, a global status word, a channel-control word, and a four-register window for each channel. Every register answers at four consecutive word addresses. A write to the first address replaces the value. The second ORs the data in, the third clears the bits that are set in the data, and the fourth XORs the data in. Software can therefore change single bits without a read-modify-write.

The engine behind the channels is not part of the block. It appears only as inputs: a one-cycle completion event per channel, a ready flag per channel, the number of the active channel and a key-ready flag. The completion events latch into per-channel pending flags. These flags, qualified by per-channel enables, drive two level interrupt outputs. A merge bit decides whether channel 0 shares the main interrupt line or uses a line of its own. A soft-reset bit holds all other storage at its reset value. A clock-gate bit blanks every read except reads of the control word.

Top module: `alias_csr_bank`

## Requirements
- R1: A write to alias offset +0x0 of a register replaces its writable bits with the data. Bits 1:0 of a channel pointer are not writable and always read 0.
- R2: A write to alias offset +0x4 ORs the data into the writable bits.
- R3: A write to alias offset +0x8 clears every writable bit that is 1 in the data. This is also how pending flags in status bits 3:0 are acknowledged.
- R4: A write to alias offset +0xC inverts every writable bit that is 1 in the data.
- R5: A read at any of the four alias addresses of a register returns the register's value.
- R6: Read-only fields ignore writes through all four aliases. Control bits 29 and 28 return the cipher-present and hash-present parameters. Status bits 28, 27:24 and 19:16 show the key-ready, active-channel and channel-ready inputs. Unused bits read 0. The writable masks are: control 0xC0E0000F, status 0x0000000F, channel control 0x00010F0F, pointer 0xFFFFFFFC, semaphore 0x000000FF, channel status 0x00FF007E, options 0xFFFFFFFF.
- R7: Channel c (0 to 3) has its pointer, semaphore, status and options registers at 0x100, 0x110, 0x120 and 0x130 plus 0x40 times c. Channels do not alias one another.
- R8: A completion event on channel c sets status bit c on the next edge. If a write clears that bit in the same cycle, the event wins. Clear bits without an event still clear.
- R9: Pending equals status bits 3:0 AND control bits 3:0. `irq_o` is the OR of pending for channels 1 to 3, plus channel 0 when channel-control bit 16 (merge) is 1. `irq_ch0_o` is channel 0 pending while merge is 0, and 0 while merge is 1.
- R10: While control bit 31 is 1, every other stored bit returns to 0 on the next edge. Writes to other registers and completion events are then ignored. Bit 31 holds until software clears it.
- R11: While control bit 30 is 1, reads of every address other than the control word return 0.
- R12: A misaligned address, an address in the global space at or above 0x030, or an address at or above 0x200 reads 0, and a write there changes nothing.
- R13: After reset, all stored bits are 0. The control word reads back only the feature-present bits (0x30000000 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Byte address; bits 3:2 select the alias |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| ev_done_i | input | NUM_CH | One-cycle completion event per channel |
| chan_ready_i | input | NUM_CH | Channel-ready flags shown in status |
| cur_chan_i | input | 4 | Active channel number shown in status |
| key_ready_i | input | 1 | Key-ready flag shown in status |
| irq_o | output | 1 | Main level interrupt |
| irq_ch0_o | output | 1 | Separate channel 0 interrupt when not merged |

## Verification
The status flags have two writers that can act in the same cycle: a completion event from the engine and a software write that clears flags through the clear or plain alias. The bench raises an event on one channel in the same cycle as a clear write. The clear covers both that channel and a channel without an event. The status word read afterwards must keep the event's bit and drop only the other one. A second case clears exactly the bit whose event fires and expects it to stay set. The interrupt outputs are sampled across the change as well.

// File: rtl/alias_csr_pkg.sv
package alias_csr_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_FLIP  = 2'd3
  } alias_op_e;

  localparam int unsigned CH_BASE     = 32'h100;
  localparam int unsigned CH_STRIDE_SH = 6;
  localparam int unsigned CH_REGS     = 4;

  localparam logic [31:0] CTRL_SRST_BIT = 32'h8000_0000;
  localparam logic [31:0] CTRL_FIXED_W  = 32'hC0E0_0000;
  localparam logic [31:0] CHCTRL_FIXED_W = 32'h0001_0000;

  // Writable bits of the four per-channel registers: pointer, semaphore, status, options
  function automatic logic [31:0] chan_reg_mask(int unsigned idx);
    case (idx)
      0:       return 32'hFFFF_FFFC;
      1:       return 32'h0000_00FF;
      2:       return 32'h00FF_007E;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // Next value of a register under one alias access; only bits in wmask move
  function automatic logic [31:0] alias_apply(alias_op_e op, logic [31:0] cur,
                                              logic [31:0] d, logic [31:0] wmask);
    logic [31:0] nxt;
    case (op)
      OP_WRITE: nxt = d;
      OP_SET:   nxt = cur | d;
      OP_CLEAR: nxt = cur & ~d;
      default:  nxt = cur ^ d;
    endcase
    return (cur & ~wmask) | (nxt & wmask);
  endfunction

endpackage

// File: rtl/alias_csr_decode.sv
module alias_csr_decode
  import alias_csr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_CH = 4,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output alias_op_e         op,
  output logic              sel_ctrl,
  output logic              sel_stat,
  output logic              sel_chctrl,
  output logic              chan_hit,
  output logic [IDX_W-1:0]  chan_idx,
  output logic [1:0]        chan_reg,
  output logic              unmapped
);
  logic              aligned;
  logic [ADDR_W-5:0] blk;
  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] ch_no;

  always_comb begin
    aligned    = (addr[1:0] == 2'b00);
    blk        = addr[ADDR_W-1:4];
    op         = alias_op_e'(addr[3:2]);
    sel_ctrl   = aligned && (blk == (ADDR_W-4)'(0));
    sel_stat   = aligned && (blk == (ADDR_W-4)'(1));
    sel_chctrl = aligned && (blk == (ADDR_W-4)'(2));
    off        = addr - ADDR_W'(CH_BASE);
    ch_no      = off >> CH_STRIDE_SH;
    chan_hit   = aligned && (addr >= ADDR_W'(CH_BASE)) && (ch_no < ADDR_W'(NUM_CH));
    chan_idx   = ch_no[IDX_W-1:0];
    chan_reg   = off[5:4];
    unmapped   = !(sel_ctrl || sel_stat || sel_chctrl || chan_hit);
  end
endmodule

// File: rtl/alias_csr_chan.sv
module alias_csr_chan
  import alias_csr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sreset,
  input  logic                     wr,
  input  logic [1:0]               reg_sel,
  input  alias_op_e                op,
  input  logic [31:0]              wdata,
  output logic [CH_REGS-1:0][31:0] regs_o
);
  for (genvar r = 0; r < CH_REGS; r++) begin : g_reg
    localparam logic [31:0] WMASK = chan_reg_mask(r);
    logic [31:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (sreset)
        q <= '0;
      else if (wr && reg_sel == 2'(r))
        q <= alias_apply(op, q, wdata, WMASK);
    end
    assign regs_o[r] = q;
  end
endmodule

// File: rtl/alias_csr_global.sv
module alias_csr_global
  import alias_csr_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              sel_ctrl,
  input  logic              sel_stat,
  input  logic              sel_chctrl,
  input  alias_op_e         op,
  input  logic [31:0]       wdata,
  input  logic [NUM_CH-1:0] ev_done,
  output logic [31:0]       ctrl_q,
  output logic [31:0]       chctrl_q,
  output logic [NUM_CH-1:0] flags_q,
  output logic              sreset
);
  localparam logic [31:0] CH_MASK     = 32'((64'd1 << NUM_CH) - 64'd1);
  localparam logic [31:0] CTRL_WMASK  = CTRL_FIXED_W | CH_MASK;
  localparam logic [31:0] CHCTRL_WMASK = CHCTRL_FIXED_W | (CH_MASK << 8) | CH_MASK;

  logic [31:0]       ctrl_d, chctrl_d, flags_wr;
  logic [NUM_CH-1:0] flags_d;

  assign sreset = ctrl_q[31];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr && sel_ctrl)
      ctrl_d = alias_apply(op, ctrl_q, wdata, CTRL_WMASK);
    if (sreset)
      ctrl_d = ctrl_d & CTRL_SRST_BIT;

    chctrl_d = chctrl_q;
    if (sreset)
      chctrl_d = '0;
    else if (wr && sel_chctrl)
      chctrl_d = alias_apply(op, chctrl_q, wdata, CHCTRL_WMASK);

    flags_wr = 32'(flags_q);
    if (wr && sel_stat)
      flags_wr = alias_apply(op, 32'(flags_q), wdata, CH_MASK);
    flags_d = sreset ? '0 : (flags_wr[NUM_CH-1:0] | ev_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      chctrl_q <= '0;
      flags_q  <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      chctrl_q <= chctrl_d;
      flags_q  <= flags_d;
    end
  end
endmodule

// File: rtl/alias_csr_bank.sv
module alias_csr_bank
  import alias_csr_pkg::*;
#(
  parameter int   ADDR_W     = 12,
  parameter int   NUM_CH     = 4,
  parameter logic HAS_CIPHER = 1'b1,
  parameter logic HAS_HASH   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_CH-1:0] ev_done_i,
  input  logic [NUM_CH-1:0] chan_ready_i,
  input  logic [3:0]        cur_chan_i,
  input  logic              key_ready_i,
  output logic              irq_o,
  output logic              irq_ch0_o
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [31:0] FEAT_BITS = {2'b00, HAS_CIPHER, HAS_HASH, 28'h0};
  localparam logic [NUM_CH-1:0] NOT_CH0 = {{(NUM_CH-1){1'b1}}, 1'b0};

  alias_op_e         op;
  logic              sel_ctrl, sel_stat, sel_chctrl, chan_hit, acc_unmapped;
  logic [IDX_W-1:0]  chan_idx;
  logic [1:0]        chan_reg;
  logic [31:0]       ctrl_q, chctrl_q;
  logic [NUM_CH-1:0] flags_q, pending;
  logic              sreset, clk_gate, merge_ch0;
  logic [31:0]       stat_word, rd_raw;
  logic [NUM_CH-1:0][CH_REGS-1:0][31:0] chan_regs;

  alias_csr_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
    .addr(bus_addr), .op(op), .sel_ctrl(sel_ctrl), .sel_stat(sel_stat),
    .sel_chctrl(sel_chctrl), .chan_hit(chan_hit), .chan_idx(chan_idx),
    .chan_reg(chan_reg), .unmapped(acc_unmapped)
  );

  alias_csr_global #(.NUM_CH(NUM_CH)) u_glb (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel_ctrl(sel_ctrl),
    .sel_stat(sel_stat), .sel_chctrl(sel_chctrl), .op(op), .wdata(bus_wdata),
    .ev_done(ev_done_i), .ctrl_q(ctrl_q), .chctrl_q(chctrl_q),
    .flags_q(flags_q), .sreset(sreset)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic wr_c;
    assign wr_c = bus_wr && chan_hit && (chan_idx == IDX_W'(c));
    alias_csr_chan u_chan (
      .clk(clk), .rst_n(rst_n), .sreset(sreset), .wr(wr_c),
      .reg_sel(chan_reg), .op(op), .wdata(bus_wdata), .regs_o(chan_regs[c])
    );
  end

  assign clk_gate  = ctrl_q[30];
  assign merge_ch0 = chctrl_q[16];
  assign pending   = flags_q & ctrl_q[NUM_CH-1:0];
  assign irq_o     = |(pending & NOT_CH0) | (merge_ch0 & pending[0]);
  assign irq_ch0_o = pending[0] & ~merge_ch0;

  always_comb begin
    stat_word = 32'(flags_q) | (32'(chan_ready_i) << 16) |
                (32'(cur_chan_i) << 24) | (32'(key_ready_i) << 28);
    if (sel_ctrl)        rd_raw = ctrl_q | FEAT_BITS;
    else if (sel_stat)   rd_raw = stat_word;
    else if (sel_chctrl) rd_raw = chctrl_q;
    else if (chan_hit)   rd_raw = chan_regs[chan_idx][chan_reg];
    else                 rd_raw = '0;
    bus_rdata = (clk_gate && !sel_ctrl) ? 32'h0 : rd_raw;
  end
endmodule

// File: rtl/alias_csr_chk.sv
module alias_csr_chk #(
  parameter int   ADDR_W     = 12,
  parameter int   NUM_CH     = 4,
  parameter logic HAS_CIPHER = 1'b1,
  parameter logic HAS_HASH   = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [31:0]       bus_rdata,
  input logic [NUM_CH-1:0] ev_done_i,
  input logic              irq_ch0_o,
  input logic              sreset,
  input logic              clk_gate,
  input logic              acc_unmapped,
  input logic              sel_ctrl,
  input logic [31:0]       ctrl_q,
  input logic [31:0]       chctrl_q,
  input logic [NUM_CH-1:0] flags_q
);
  // R8
  event_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done_i != '0 && !sreset) |=> ((flags_q & $past(ev_done_i)) == $past(ev_done_i)));

  // R10
  soft_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sreset |=> (flags_q == '0 && chctrl_q == '0 && ctrl_q[30:0] == '0));

  // R12
  unmapped_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && acc_unmapped && !sreset) |=> ($stable(ctrl_q) && $stable(chctrl_q)));

  // R11
  gated_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_gate && !sel_ctrl) |-> (bus_rdata == 32'h0));

  // R6
  feature_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ctrl |-> (bus_rdata[29:28] == {HAS_CIPHER, HAS_HASH}));

  // R9
  merge_silences_ch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chctrl_q[16] |-> !irq_ch0_o);
endmodule

bind alias_csr_bank alias_csr_chk #(
  .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .HAS_CIPHER(HAS_CIPHER), .HAS_HASH(HAS_HASH)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
  .ev_done_i(ev_done_i), .irq_ch0_o(irq_ch0_o), .sreset(sreset),
  .clk_gate(clk_gate), .acc_unmapped(acc_unmapped), .sel_ctrl(sel_ctrl),
  .ctrl_q(ctrl_q), .chctrl_q(chctrl_q), .flags_q(flags_q)
);

// File: tb/alias_csr_bank_tb_top.sv
module alias_csr_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  ev_done_i = '0;
  logic [3:0]  chan_ready_i = '0;
  logic [3:0]  cur_chan_i = '0;
  logic        key_ready_i = 1'b0;
  logic        irq_o, irq_ch0_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  alias_csr_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_done_i(ev_done_i),
    .chan_ready_i(chan_ready_i), .cur_chan_i(cur_chan_i),
    .key_ready_i(key_ready_i), .irq_o(irq_o), .irq_ch0_o(irq_ch0_o)
  );

  // {write addr, write data, read addr, expected read, requirement number}
  localparam int NVEC = 19;
  localparam logic [95:0] VEC [NVEC] = '{
    {12'h100, 32'h1234_5677, 12'h100, 32'h1234_5674, 8'd1},  // R1 pointer low bits fixed
    {12'h104, 32'h8000_0008, 12'h10C, 32'h9234_567C, 8'd2},  // R2 set alias
    {12'h108, 32'h0000_0074, 12'h108, 32'h9234_5608, 8'd3},  // R3 clear alias
    {12'h10C, 32'hFFFF_FFFF, 12'h104, 32'h6DCB_A9F4, 8'd4},  // R4 toggle alias
    {12'h150, 32'h0000_01FF, 12'h150, 32'h0000_00FF, 8'd7},  // R7 ch1 semaphore
    {12'h1E0, 32'hFFFF_FFFF, 12'h1E0, 32'h00FF_007E, 8'd6},  // R6 ch3 status mask
    {12'h1B0, 32'hA5A5_5A5A, 12'h1B0, 32'hA5A5_5A5A, 8'd7},  // R7 ch2 options
    {12'h1F0, 32'h0000_0011, 12'h1B0, 32'hA5A5_5A5A, 8'd7},  // R7 ch3 leaves ch2
    {12'h1F4, 32'h0000_0100, 12'h1F8, 32'h0000_0111, 8'd5},  // R5 read via clear alias
    {12'h000, 32'h0FFF_FFFF, 12'h000, 32'h30E0_000F, 8'd6},  // R6 control mask
    {12'h008, 32'h3000_0000, 12'h000, 32'h30E0_000F, 8'd6},  // R6 feature bits fixed
    {12'h024, 32'hFFFF_FFFF, 12'h020, 32'h0001_0F0F, 8'd2},  // R2 channel control
    {12'h02C, 32'h0001_0001, 12'h028, 32'h0000_0F0E, 8'd4},  // R4 channel control
    {12'h200, 32'hFFFF_FFFF, 12'h200, 32'h0000_0000, 8'd12}, // R12 beyond windows
    {12'h101, 32'h0000_0000, 12'h100, 32'h6DCB_A9F4, 8'd12}, // R12 misaligned
    {12'h040, 32'hFFFF_FFFF, 12'h030, 32'h0000_0000, 8'd12}, // R12 global hole
    {12'h014, 32'hFFFF_FFFF, 12'h010, 32'h0000_000F, 8'd6},  // R6 status RO fields
    {12'h018, 32'h0000_0005, 12'h010, 32'h0000_000A, 8'd3},  // R3 acknowledge flags
    {12'h01C, 32'h0000_0003, 12'h01C, 32'h0000_0009, 8'd4}   // R4 status toggle
  };

  task automatic check32(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %08h expected %08h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic read_check(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    check32(req, $sformatf("read %03h", a), d, exp);
  endtask

  task automatic irq_check(string req, logic exp_main, logic exp_ch0);
    #1;
    check32(req, "irq_o", 32'(irq_o), 32'(exp_main));
    check32(req, "irq_ch0_o", 32'(irq_ch0_o), 32'(exp_ch0));
  endtask

  // write and completion event in the same cycle
  task automatic write_with_event(logic [11:0] a, logic [31:0] d, logic [3:0] ev);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; ev_done_i = ev;
    @(negedge clk);
    bus_wr = 1'b0; ev_done_i = '0;
  endtask

  task automatic pulse_event(logic [3:0] ev);
    @(negedge clk);
    ev_done_i = ev;
    @(negedge clk);
    ev_done_i = '0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    read_check("R13", 12'h000, 32'h3000_0000);
    read_check("R13", 12'h010, 32'h0000_0000);
    read_check("R13", 12'h100, 32'h0000_0000);
    irq_check("R13", 1'b0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] d;
      bus_write(VEC[i][95:84], VEC[i][83:52]);
      bus_read(VEC[i][51:40], d);
      check32($sformatf("R%0d", VEC[i][7:0]), $sformatf("vector %0d", i), d, VEC[i][39:8]);
    end

    // R9 flags 0x9, enables 0xF, merge off
    irq_check("R9", 1'b1, 1'b1);
    bus_write(12'h018, 32'hF);
    irq_check("R9", 1'b0, 1'b0);
    pulse_event(4'b0001);
    irq_check("R9", 1'b0, 1'b1);
    bus_write(12'h024, 32'h0001_0000);
    irq_check("R9", 1'b1, 1'b0);
    bus_write(12'h008, 32'h0000_0001);
    irq_check("R9", 1'b0, 1'b0);

    // R8 event on ch1 while clearing ch0 and ch1
    write_with_event(12'h018, 32'h3, 4'b0010);
    read_check("R8", 12'h010, 32'h0000_0002);
    irq_check("R8", 1'b1, 1'b0);
    write_with_event(12'h018, 32'h2, 4'b0010);
    read_check("R8", 12'h010, 32'h0000_0002);

    // R6 live read-only status fields
    key_ready_i = 1'b1; cur_chan_i = 4'h5; chan_ready_i = 4'hA;
    read_check("R6", 12'h010, 32'h150A_0002);
    bus_write(12'h010, 32'hFFFF_FFFF);
    read_check("R6", 12'h010, 32'h150A_000F);
    bus_write(12'h010, 32'h0);
    read_check("R6", 12'h010, 32'h150A_0000);
    key_ready_i = 1'b0; cur_chan_i = '0; chan_ready_i = '0;

    // R11 clock gate blanks reads except control
    bus_write(12'h004, 32'h4000_0000);
    read_check("R11", 12'h100, 32'h0);
    read_check("R11", 12'h000, 32'h70E0_000E);
    bus_write(12'h008, 32'h4000_0000);
    read_check("R11", 12'h100, 32'h6DCB_A9F4);

    // R10 soft reset
    bus_write(12'h004, 32'h8000_0000);
    @(negedge clk);
    read_check("R10", 12'h000, 32'hB000_0000);
    read_check("R10", 12'h100, 32'h0);
    read_check("R10", 12'h020, 32'h0);
    bus_write(12'h1B0, 32'h0000_1234);
    read_check("R10", 12'h1B0, 32'h0);
    pulse_event(4'hF);
    read_check("R10", 12'h010, 32'h0);
    bus_write(12'h008, 32'h8000_0000);
    read_check("R10", 12'h000, 32'h3000_0000);
    bus_write(12'h100, 32'h0000_0010);
    read_check("R1", 12'h100, 32'h0000_0010);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule